// File: doc/BRIEF.md
# In-band Xon/Xoff flow control tracker

This block handles software flow control for a single serial channel. It compares each character the receiver delivers against two programmable match values, one for "resume" (Xon) and one for "stop" (Xoff). From those matches it runs a small transmitter flow machine. When a stop character arrives, the transmitter is told to halt once the character in flight has finished. When a resume character arrives, the transmitter is released again.

In automatic receive flow mode, the block also watches a level from the receive buffer that says the buffer is nearly full. It then asks the serializer to insert a stop character, or a resume character once the level has dropped. An inserted character always goes ahead of the next data character, and data waits one bit time after each insertion.

A host reaches the two match values and an 8-bit status word through a small register port. Reading the status word has side effects. It clears the record of received flow characters, and it moves the re-enabled flow state back to normal.

Top module: `xflow_tracker`

## Requirements
- R1: After reset, the status word (address 2) reads 0x00, the Xon match value (address 0) reads 0x11, the Xoff match value (address 1) reads 0x13, and tx_halt, ins_xon, ins_xoff and flow_event are low.
- R2: A write to address 0 replaces the Xon match value, and a write to address 1 replaces the Xoff match value. Each value reads back from its own address from the next cycle on.
- R3: Status bits 7:6 record received flow characters (bit 6 = Xoff seen, bit 7 = Xon seen, so 01 Xoff, 10 Xon, 11 both). They are set one cycle after a matching rx_valid, whatever the state of auto_en. They hold until a status read (reg_re at address 2), which clears them on the next cycle unless a new match arrives in the same cycle.
- R4: Status bits 3:2 hold the flow state (00 normal, 01 halt pending, 10 re-enabled, 11 stopped). An Xoff match in normal or re-enabled goes to halt pending. Halt pending goes to stopped on tx_char_done, or on any cycle where tx_busy is low.
- R5: An Xon match in halt pending or stopped goes to re-enabled. Re-enabled returns to normal on a status read. When one character matches both values, it is treated as Xoff.
- R6: tx_halt is high exactly while the flow state is halt pending or stopped.
- R7: Status bits 1:0 hold the character type (00 data, 01 waiting, 10 Xoff queued, 11 Xon queued). From 00 with auto_en high, near_full high and the last-sent field not Xoff, the type goes to 10 and ins_xoff rises. With near_full low and the last-sent field Xoff, the type goes to 11 and ins_xon rises.
- R8: Status bits 5:4 hold the last automatically sent character (00 none, 01 Xon, 10 Xoff; 11 never appears). On ctrl_sent while a character is queued, this field takes that character and the type goes to 01. The type leaves 01 for 00 on a bit_tick while tx_fifo_empty is low.
- R9: tx_data_ok is high only when tx_halt is low and the character type is 00, so a queued insertion or the wait state always holds off data.
- R10: While auto_en is low, the last-sent field is cleared to 00 on the next cycle, and a queued insertion is dropped (type back to 00).
- R11: flow_event pulses high for one cycle, one cycle after each received character that matches either value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| tx_busy | input | 1 | Serializer is shifting a character |
| tx_char_done | input | 1 | Serializer finished a character |
| tx_fifo_empty | input | 1 | Transmit buffer holds no data |
| bit_tick | input | 1 | One pulse per bit time |
| ctrl_sent | input | 1 | Queued flow character has been sent |
| auto_en | input | 1 | Automatic receive flow mode enable |
| near_full | input | 1 | Receive buffer above its threshold |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (side effects) |
| reg_addr | input | 2 | Register address: 0 Xon, 1 Xoff, 2 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tx_halt | output | 1 | Do not start a new data character |
| ins_xon | output | 1 | Request to insert Xon next |
| ins_xoff | output | 1 | Request to insert Xoff next |
| tx_data_ok | output | 1 | Next data character may start |
| flow_event | output | 1 | Flow character received (interrupt source) |

## Verification
Some rules are checked by assertions on every cycle. The stopped state is entered only from halt pending, and re-enabled only from a halted state. The wait type follows only a sent acknowledgement. The last-sent field never holds 11 and clears whenever auto mode is off. The received record stays stable when nothing touches it, and data is always blocked while an insertion is queued. Other behaviour only shows up through the bench's scenarios, which compare against a cycle-by-cycle model. This covers the ordering when a read and a new match land in the same cycle, Xoff winning when both values are equal, the wait type holding while the transmit buffer is empty, and the full automatic stop-then-resume round trip.

// File: rtl/xflow_pkg.sv
package xflow_pkg;

  typedef enum logic [1:0] {
    FL_NORMAL    = 2'b00,
    FL_HALT_PEND = 2'b01,
    FL_REENABLED = 2'b10,
    FL_STOPPED   = 2'b11
  } flow_st_e;

  typedef enum logic [1:0] {
    CT_DATA   = 2'b00,
    CT_WAIT   = 2'b01,
    CT_XOFF_Q = 2'b10,
    CT_XON_Q  = 2'b11
  } char_ty_e;

  localparam logic [1:0] SENT_NONE = 2'b00;
  localparam logic [1:0] SENT_XON  = 2'b01;
  localparam logic [1:0] SENT_XOFF = 2'b10;

endpackage

// File: rtl/xflow_match.sv
module xflow_match #(
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  XON_RST  = 8'h11,
  parameter logic [7:0]  XOFF_RST = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_on,
  input  logic              we_off,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic [DATA_W-1:0] on_val,
  output logic [DATA_W-1:0] off_val,
  output logic              hit_on,
  output logic              hit_off
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_val  <= DATA_W'(XON_RST);
      off_val <= DATA_W'(XOFF_RST);
    end else begin
      if (we_on)  on_val  <= wdata;
      if (we_off) off_val <= wdata;
    end
  end

  always_comb begin
    hit_on  = rx_valid && (rx_data == on_val);
    hit_off = rx_valid && (rx_data == off_val);
  end

endmodule

// File: rtl/xflow_state.sv
module xflow_state
  import xflow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_on,
  input  logic       hit_off,
  input  logic       stat_rd,
  input  logic       tx_char_done,
  input  logic       tx_busy,
  output flow_st_e   flow_st,
  output logic [1:0] rx_seen,
  output logic       evt
);

  flow_st_e   flow_nx;
  logic [1:0] seen_nx;
  logic       on_eff;
  logic       flow_en;
  logic       seen_en;

  always_comb begin
    on_eff  = hit_on & ~hit_off;
    flow_nx = flow_st;
    case (flow_st)
      FL_NORMAL:    if (hit_off) flow_nx = FL_HALT_PEND;
      FL_HALT_PEND: begin
        if (on_eff)                         flow_nx = FL_REENABLED;
        else if (tx_char_done || !tx_busy)  flow_nx = FL_STOPPED;
      end
      FL_STOPPED:   if (on_eff) flow_nx = FL_REENABLED;
      FL_REENABLED: begin
        if (hit_off)      flow_nx = FL_HALT_PEND;
        else if (stat_rd) flow_nx = FL_NORMAL;
      end
      default:      flow_nx = FL_NORMAL;
    endcase
    seen_nx = (stat_rd ? 2'b00 : rx_seen) | {hit_on, hit_off};
    flow_en = (flow_nx != flow_st);
    seen_en = stat_rd | hit_on | hit_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flow_st <= FL_NORMAL;
      rx_seen <= 2'b00;
      evt     <= 1'b0;
    end else begin
      if (flow_en) flow_st <= flow_nx;
      if (seen_en) rx_seen <= seen_nx;
      evt <= hit_on | hit_off;
    end
  end

  AST_STOP_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_st == FL_STOPPED && $past(flow_st) != FL_STOPPED) |-> $past(flow_st) == FL_HALT_PEND); // R4
  AST_REEN_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_st == FL_REENABLED && $past(flow_st) != FL_REENABLED)
      |-> ($past(flow_st) == FL_HALT_PEND || $past(flow_st) == FL_STOPPED)); // R5
  AST_SEEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_rd && !hit_on && !hit_off) |=> $stable(rx_seen)); // R3
  AST_EVT_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> $past(hit_on || hit_off)); // R11

endmodule

// File: rtl/xflow_auto.sv
module xflow_auto
  import xflow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       auto_en,
  input  logic       near_full,
  input  logic       ctrl_sent,
  input  logic       bit_tick,
  input  logic       fifo_empty,
  output char_ty_e   ctype,
  output logic [1:0] last_sent
);

  char_ty_e   ct_nx;
  logic [1:0] last_nx;
  logic       ct_en;
  logic       last_en;

  always_comb begin
    ct_nx   = ctype;
    last_nx = last_sent;
    if (!auto_en) last_nx = SENT_NONE;
    case (ctype)
      CT_XOFF_Q, CT_XON_Q: begin
        if (!auto_en) begin
          ct_nx = CT_DATA;
        end else if (ctrl_sent) begin
          ct_nx   = CT_WAIT;
          last_nx = (ctype == CT_XOFF_Q) ? SENT_XOFF : SENT_XON;
        end
      end
      CT_WAIT: if (bit_tick && !fifo_empty) ct_nx = CT_DATA;
      default: begin
        if (auto_en) begin
          if (near_full && last_sent != SENT_XOFF)       ct_nx = CT_XOFF_Q;
          else if (!near_full && last_sent == SENT_XOFF) ct_nx = CT_XON_Q;
        end
      end
    endcase
    ct_en   = (ct_nx != ctype);
    last_en = (last_nx != last_sent);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctype     <= CT_DATA;
      last_sent <= SENT_NONE;
    end else begin
      if (ct_en)   ctype     <= ct_nx;
      if (last_en) last_sent <= last_nx;
    end
  end

  AST_WAIT_AFTER_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctype == CT_WAIT && $past(ctype) != CT_WAIT) |-> $past(ctrl_sent)); // R8
  AST_LAST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    last_sent != 2'b11); // R8
  AST_AUTO_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> (last_sent == SENT_NONE && ctype != CT_XOFF_Q && ctype != CT_XON_Q)); // R10

endmodule

// File: rtl/xflow_tracker.sv
module xflow_tracker
  import xflow_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         ADDR_W   = 2,
  parameter logic [7:0] XON_RST  = 8'h11,
  parameter logic [7:0] XOFF_RST = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              tx_busy,
  input  logic              tx_char_done,
  input  logic              tx_fifo_empty,
  input  logic              bit_tick,
  input  logic              ctrl_sent,
  input  logic              auto_en,
  input  logic              near_full,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              tx_halt,
  output logic              ins_xon,
  output logic              ins_xoff,
  output logic              tx_data_ok,
  output logic              flow_event
);

  localparam logic [ADDR_W-1:0] A_ON   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);

  logic [1:0]        rst_sync;
  logic              rst_s_n;
  logic [DATA_W-1:0] on_val;
  logic [DATA_W-1:0] off_val;
  logic              hit_on;
  logic              hit_off;
  logic              stat_rd;
  flow_st_e          flow_st;
  logic [1:0]        rx_seen;
  char_ty_e          ctype;
  logic [1:0]        last_sent;
  logic [DATA_W-1:0] stat_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign stat_rd = reg_re && (reg_addr == A_STAT);

  xflow_match #(.DATA_W(DATA_W), .XON_RST(XON_RST), .XOFF_RST(XOFF_RST)) u_match (
    .clk(clk), .rst_n(rst_s_n),
    .we_on(reg_we && reg_addr == A_ON), .we_off(reg_we && reg_addr == A_OFF),
    .wdata(reg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .on_val(on_val), .off_val(off_val), .hit_on(hit_on), .hit_off(hit_off)
  );

  xflow_state u_state (
    .clk(clk), .rst_n(rst_s_n), .hit_on(hit_on), .hit_off(hit_off),
    .stat_rd(stat_rd), .tx_char_done(tx_char_done), .tx_busy(tx_busy),
    .flow_st(flow_st), .rx_seen(rx_seen), .evt(flow_event)
  );

  xflow_auto u_auto (
    .clk(clk), .rst_n(rst_s_n), .auto_en(auto_en), .near_full(near_full),
    .ctrl_sent(ctrl_sent), .bit_tick(bit_tick), .fifo_empty(tx_fifo_empty),
    .ctype(ctype), .last_sent(last_sent)
  );

  always_comb begin
    stat_word      = '0;
    stat_word[7:0] = {rx_seen, last_sent, flow_st, ctype};
    case (reg_addr)
      A_ON:    reg_rdata = on_val;
      A_OFF:   reg_rdata = off_val;
      A_STAT:  reg_rdata = stat_word;
      default: reg_rdata = '0;
    endcase
    tx_halt    = (flow_st == FL_HALT_PEND) || (flow_st == FL_STOPPED);
    ins_xoff   = (ctype == CT_XOFF_Q);
    ins_xon    = (ctype == CT_XON_Q);
    tx_data_ok = !tx_halt && (ctype == CT_DATA);
  end

  AST_INSERT_FIRST: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ins_xon || ins_xoff) |-> !tx_data_ok); // R9
  AST_ONE_INSERT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({ins_xon, ins_xoff})); // R7

endmodule

// File: tb/test_xflow_tracker.sv
module test_xflow_tracker;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 0, tx_busy = 0, tx_char_done = 0, tx_fifo_empty = 1;
  logic       bit_tick = 0, ctrl_sent = 0, auto_en = 0, near_full = 0;
  logic       reg_we = 0, reg_re = 0;
  logic [1:0] reg_addr = 2'd2;
  logic [7:0] rx_data = 8'h00, reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tx_halt, ins_xon, ins_xoff, tx_data_ok, flow_event;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // behavioural model state
  int m_on, m_off, m_seen, m_fs, m_ct, m_last;
  bit m_evt;

  always #4 clk = ~clk;

  xflow_tracker i_xflow_tracker (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_busy(tx_busy), .tx_char_done(tx_char_done), .tx_fifo_empty(tx_fifo_empty),
    .bit_tick(bit_tick), .ctrl_sent(ctrl_sent), .auto_en(auto_en), .near_full(near_full),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_halt(tx_halt), .ins_xon(ins_xon), .ins_xoff(ins_xoff),
    .tx_data_ok(tx_data_ok), .flow_event(flow_event)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 'h11; m_off = 'h13; m_seen = 0; m_fs = 0; m_ct = 0; m_last = 0; m_evt = 0;
    end else begin
      bit hon, hoff, rd;
      int nfs, nct, nlast;
      hon  = rx_valid && (rx_data == m_on);
      hoff = rx_valid && (rx_data == m_off);
      rd   = reg_re && (reg_addr == 2);
      nfs = m_fs;
      if (m_fs == 0 && hoff) nfs = 1;
      else if (m_fs == 1) begin
        if (hon && !hoff) nfs = 2;
        else if (tx_char_done || !tx_busy) nfs = 3;
      end else if (m_fs == 3 && hon && !hoff) nfs = 2;
      else if (m_fs == 2) begin
        if (hoff) nfs = 1;
        else if (rd) nfs = 0;
      end
      nct = m_ct; nlast = auto_en ? m_last : 0;
      if (m_ct >= 2) begin
        if (!auto_en) nct = 0;
        else if (ctrl_sent) begin nct = 1; nlast = (m_ct == 2) ? 2 : 1; end
      end else if (m_ct == 1) begin
        if (bit_tick && !tx_fifo_empty) nct = 0;
      end else if (auto_en) begin
        if (near_full && m_last != 2) nct = 2;
        else if (!near_full && m_last == 2) nct = 3;
      end
      m_seen = (rd ? 0 : m_seen) | (hon ? 2 : 0) | (hoff ? 1 : 0);
      m_fs = nfs; m_ct = nct; m_last = nlast;
      m_evt = hon || hoff;
      if (reg_we && reg_addr == 0) m_on = reg_wdata;
      if (reg_we && reg_addr == 1) m_off = reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int exp_rd;
    if (reg_addr == 2) begin
      chk(reg_rdata[7:6] == m_seen[1:0], "R3 received field", reg_rdata[7:6], m_seen);
      chk(reg_rdata[5:4] == m_last[1:0], "R8 last-sent field", reg_rdata[5:4], m_last);
      chk(reg_rdata[3:2] == m_fs[1:0],   "R4,R5 flow field",  reg_rdata[3:2], m_fs);
      chk(reg_rdata[1:0] == m_ct[1:0],   "R7 char-type field", reg_rdata[1:0], m_ct);
    end else begin
      exp_rd = (reg_addr == 0) ? m_on : (reg_addr == 1) ? m_off : 0;
      chk(reg_rdata == exp_rd[7:0], "R2 match readback", reg_rdata, exp_rd);
    end
    chk(tx_halt == (m_fs == 1 || m_fs == 3), "R6 tx_halt", tx_halt, (m_fs == 1 || m_fs == 3));
    chk(ins_xoff == (m_ct == 2), "R7 ins_xoff", ins_xoff, (m_ct == 2));
    chk(ins_xon == (m_ct == 3), "R7 ins_xon", ins_xon, (m_ct == 3));
    chk(tx_data_ok == (m_fs != 1 && m_fs != 3 && m_ct == 0), "R9 tx_data_ok",
        tx_data_ok, (m_fs != 1 && m_fs != 3 && m_ct == 0));
    chk(flow_event == m_evt, "R11 flow_event", flow_event, m_evt);
  endtask

  // one cycle: wait for the falling edge, compare, then clear the pulse inputs
  task automatic tick();
    @(negedge clk);
    compare_all();
    rx_valid = 0; tx_char_done = 0; bit_tick = 0; ctrl_sent = 0; reg_we = 0; reg_re = 0;
  endtask

  task automatic peek(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp[7:0], tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic rx(input logic [7:0] d);
    rx_valid = 1; rx_data = d; tick();
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    peek(2'd0, 'h11, "R1 Xon reset value");
    peek(2'd1, 'h13, "R1 Xoff reset value");
    peek(2'd2, 'h00, "R1 status reset value");
    chk(!tx_halt && !ins_xon && !ins_xoff && !flow_event, "R1 outputs idle",
        {tx_halt, ins_xon, ins_xoff, flow_event}, 0);
    // R2 writes
    wr(2'd0, 8'h55); peek(2'd0, 'h55, "R2 Xon written");
    wr(2'd1, 8'hAA); peek(2'd1, 'hAA, "R2 Xoff written");
    reg_addr = 2'd2;
    // R4 halt pending then stopped
    tx_busy = 1;
    rx(8'hAA);
    peek(2'd2, 'h44, "R4 halt pending after Xoff");
    chk(tx_halt == 1, "R6 halt while pending", tx_halt, 1);
    chk(flow_event == 1, "R11 event after Xoff", flow_event, 1);
    tick();
    peek(2'd2, 'h44, "R4 pending holds while busy");
    tx_char_done = 1; tick();
    peek(2'd2, 'h4C, "R4 stopped after char done");
    rx(8'h55);
    peek(2'd2, 'hC8, "R5 re-enabled after Xon");
    chk(tx_halt == 0, "R6 released", tx_halt, 0);
    reg_re = 1; tick();
    peek(2'd2, 'h00, "R3,R5 read clears record and re-enabled");
    // both values equal: Xoff wins
    wr(2'd0, 8'hAA); reg_addr = 2'd2;
    rx(8'hAA);
    peek(2'd2, 'hC4, "R5 equal values act as Xoff");
    tx_busy = 0; reg_re = 1; tick();
    peek(2'd2, 'h0C, "R4 idle transmitter stops at once");
    wr(2'd0, 8'h55); reg_addr = 2'd2;
    rx(8'h55); reg_re = 1; tick();
    peek(2'd2, 'h00, "R5 back to normal");
    // automatic flow
    auto_en = 1; tx_fifo_empty = 0; near_full = 1; tick();
    peek(2'd2, 'h02, "R7 Xoff queued");
    chk(tx_data_ok == 0, "R9 data held for insertion", tx_data_ok, 0);
    ctrl_sent = 1; tick();
    peek(2'd2, 'h21, "R8 Xoff sent, waiting");
    tx_fifo_empty = 1; bit_tick = 1; tick();
    peek(2'd2, 'h21, "R8 wait holds with empty buffer");
    tx_fifo_empty = 0; bit_tick = 1; tick();
    peek(2'd2, 'h20, "R8 wait ends after bit time");
    near_full = 0; tick();
    peek(2'd2, 'h23, "R7 Xon queued");
    ctrl_sent = 1; tick();
    peek(2'd2, 'h11, "R8 Xon sent, waiting");
    bit_tick = 1; tick();
    peek(2'd2, 'h10, "R8 back to data");
    near_full = 1; tick();
    peek(2'd2, 'h12, "R7 Xoff queued again");
    auto_en = 0; tick();
    peek(2'd2, 'h00, "R10 auto off clears queue and field");
    // R3 records regardless of auto mode
    rx(8'h55);
    peek(2'd2, 'h80, "R3 Xon recorded with auto off");
    reg_re = 1; rx(8'hAA);
    peek(2'd2, 'h44, "R3 read with new match keeps new match");
    reg_re = 1; tx_busy = 0; tick();
    // random phase compared against the model each cycle
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 8;
      rx_valid = (r < 3);
      rx_data = (r == 0) ? 8'h55 : (r == 1) ? 8'hAA : 8'h41;
      reg_re = ($urandom % 6) == 0;
      tx_char_done = ($urandom % 5) == 0;
      tx_busy = ($urandom % 3) != 0;
      tx_fifo_empty = ($urandom % 4) == 0;
      bit_tick = ($urandom % 3) == 0;
      ctrl_sent = ($urandom % 4) == 0;
      if (($urandom % 40) == 0) near_full = ~near_full;
      if (($urandom % 150) == 0) auto_en = ~auto_en;
      tick();
    end
    done = 1;
    summary();
    $finish;
  end

endmodule